// File: doc/BRIEF.md
# Relocatable Interrupt Vector Address Generator

This block turns a vector request into the program-space address that the program counter is loaded with when a reset, interrupt or trap is taken. Vectors are soft: the core jumps to the computed address and runs the code stored there. Each vector owns a slot of four consecutive words. The whole table fills one aligned 128-word page, and a page pointer register picks that page.

Software moves the table by writing a new page number through a single-strobe write port. A hardware reset loads the pointer with all ones, so after reset the table sits at the top page of the 64K-word space, starting at FF80h. A request marked as a hardware-reset request does not use the pointer at all. It always resolves to FF80h, so the reset entry point cannot be relocated.

A request is sampled on a clock edge. The address appears on the next cycle together with a single-cycle valid strobe. The address is the page number shifted left by seven bits, OR-ed with the vector number shifted left by two bits.

Top module: `vector_addr_gen`

## Requirements
- R1: While rst_n is low and on the first cycle after it is released, vec_valid is 0 and the page pointer holds all ones (9'h1FF).
- R2: A request with req_valid=1 sampled on edge N makes vec_valid 1 for exactly the cycle after edge N; a cycle without a request leaves vec_valid at 0.
- R3: For a non-reset request, vec_addr = (page << 7) | (req_num << 2); bits 15:7 carry the page and bits 6:2 carry the vector number.
- R4: With no pointer write since reset, a user request for vector n yields FF80h + 4*n.
- R5: A request with req_hwrst=1 yields exactly FF80h, whatever the pointer value and whatever req_num holds.
- R6: A pointer write (ptr_wr=1) takes effect on the edge that samples it; a request sampled on that same edge still uses the old page.
- R7: After a pointer write, every later non-reset request resolves inside the new page; without ptr_wr the page never changes.
- R8: Requests presented while rst_n is low produce no vec_valid pulse, either during reset or after it.
- R9: Every address presented with vec_valid=1 has bits 1:0 equal to 0.
- R10: The adder-based address variant (USE_ADDER=1) gives the same vec_valid and vec_addr sequence as the default concatenation variant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ptr_wr | input | 1 | Page pointer write strobe |
| ptr_wdata | input | PAGE_W (9) | New page pointer value |
| req_valid | input | 1 | Vector request strobe |
| req_num | input | SLOT_W (5) | Vector number (0 = reset slot) |
| req_hwrst | input | 1 | Request is the hardware-reset vector |
| vec_valid | output | 1 | One-cycle strobe marking vec_addr valid |
| vec_addr | output | PAGE_W+SLOT_W+2 (16) | Program address to load into the program counter |

## Verification
The bench builds two copies with the default widths (9-bit page, 5-bit vector number, four-word slots, 16-bit address). The first uses the default concatenation path and the second uses USE_ADDER=1. Both copies receive identical stimulus, so every check also compares the two arithmetic variants cycle for cycle. These widths reach the full set of 512 pages and 32 slots, so the bench can test the corners directly: the top page FF80h, page zero, the last slot 31, and alternating bit patterns such as 155h and 0AAh. The bench also tests a pointer write that coincides with a request, and a reset request issued while the table has been moved to another page.

// File: rtl/vecgen_pkg.sv
package vecgen_pkg;

   // Default geometry: 512 pages of 128 words in a 64K-word space.
   localparam int unsigned DEF_PAGE_W     = 9;
   localparam int unsigned DEF_SLOT_W     = 5;
   localparam int unsigned DEF_WORD_SHIFT = 2;

   // Width of a vector address for a given geometry.
   function automatic int unsigned addr_width(input int unsigned page_w,
                                              input int unsigned slot_w,
                                              input int unsigned word_shift);
      return page_w + slot_w + word_shift;
   endfunction

   // Number of low address bits inside one page.
   function automatic int unsigned page_offset_bits(input int unsigned slot_w,
                                                    input int unsigned word_shift);
      return slot_w + word_shift;
   endfunction

endpackage

// File: rtl/vecgen_page_reg.sv
module vecgen_page_reg #(
   parameter int unsigned PAGE_W = vecgen_pkg::DEF_PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PAGE_W-1:0] wr_data,
   output logic [PAGE_W-1:0] page
);

   localparam logic [PAGE_W-1:0] RESET_PAGE = '1;

   if (PAGE_W < 1 || PAGE_W > 24) begin : g_bad_page_w
      $error("vecgen_page_reg: PAGE_W out of range");
   end

   logic [PAGE_W-1:0] page_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= RESET_PAGE;
      end else if (wr_en) begin
         page_q <= wr_data;
      end
   end

   assign page = page_q;

endmodule

// File: rtl/vecgen_addr_calc.sv
module vecgen_addr_calc #(
   parameter int unsigned PAGE_W     = vecgen_pkg::DEF_PAGE_W,
   parameter int unsigned SLOT_W     = vecgen_pkg::DEF_SLOT_W,
   parameter int unsigned WORD_SHIFT = vecgen_pkg::DEF_WORD_SHIFT,
   parameter bit          USE_ADDER  = 1'b0,
   localparam int unsigned ADDR_W    = vecgen_pkg::addr_width(PAGE_W, SLOT_W, WORD_SHIFT)
) (
   input  logic [PAGE_W-1:0] page,
   input  logic [SLOT_W-1:0] num,
   input  logic              hwrst,
   output logic [ADDR_W-1:0] addr
);

   localparam int unsigned OFS_W = vecgen_pkg::page_offset_bits(SLOT_W, WORD_SHIFT);
   localparam logic [PAGE_W-1:0] RESET_PAGE = '1;
   localparam logic [SLOT_W-1:0] RESET_SLOT = '0;

   if (SLOT_W < 1) begin : g_bad_slot_w
      $error("vecgen_addr_calc: SLOT_W must be at least 1");
   end
   if (ADDR_W > 32) begin : g_bad_addr_w
      $error("vecgen_addr_calc: address wider than 32 bits");
   end

   // A hardware-reset request overrides both the page and the slot.
   logic [PAGE_W-1:0] eff_page;
   logic [SLOT_W-1:0] eff_num;

   always_comb begin
      eff_page = hwrst ? RESET_PAGE : page;
      eff_num  = hwrst ? RESET_SLOT : num;
   end

   if (USE_ADDER) begin : g_adder
      logic [ADDR_W-1:0] base;
      logic [ADDR_W-1:0] offset;
      always_comb begin
         base   = {eff_page, {OFS_W{1'b0}}};
         offset = ADDR_W'({eff_num, {WORD_SHIFT{1'b0}}});
         addr   = base + offset;
      end
   end else begin : g_concat
      if (WORD_SHIFT > 0) begin : g_shift
         assign addr = {eff_page, eff_num, {WORD_SHIFT{1'b0}}};
      end else begin : g_noshift
         assign addr = {eff_page, eff_num};
      end
   end

endmodule

// File: rtl/vecgen_out_stage.sv
module vecgen_out_stage #(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr
);

   logic              valid_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
      end else begin
         valid_q <= in_valid;
         if (in_valid) begin
            addr_q <= in_addr;
         end
      end
   end

   assign out_valid = valid_q;
   assign out_addr  = addr_q;

endmodule

// File: rtl/vector_addr_gen.sv
module vector_addr_gen #(
   parameter int unsigned PAGE_W     = vecgen_pkg::DEF_PAGE_W,
   parameter int unsigned SLOT_W     = vecgen_pkg::DEF_SLOT_W,
   parameter int unsigned WORD_SHIFT = vecgen_pkg::DEF_WORD_SHIFT,
   parameter bit          USE_ADDER  = 1'b0,
   localparam int unsigned ADDR_W    = vecgen_pkg::addr_width(PAGE_W, SLOT_W, WORD_SHIFT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_wr,
   input  logic [PAGE_W-1:0] ptr_wdata,
   input  logic              req_valid,
   input  logic [SLOT_W-1:0] req_num,
   input  logic              req_hwrst,
   output logic              vec_valid,
   output logic [ADDR_W-1:0] vec_addr
);

   logic [PAGE_W-1:0] page_q;
   logic [ADDR_W-1:0] next_addr;

   vecgen_page_reg #(
      .PAGE_W (PAGE_W)
   ) u_page (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ptr_wr),
      .wr_data (ptr_wdata),
      .page    (page_q)
   );

   vecgen_addr_calc #(
      .PAGE_W     (PAGE_W),
      .SLOT_W     (SLOT_W),
      .WORD_SHIFT (WORD_SHIFT),
      .USE_ADDER  (USE_ADDER)
   ) u_calc (
      .page  (page_q),
      .num   (req_num),
      .hwrst (req_hwrst),
      .addr  (next_addr)
   );

   vecgen_out_stage #(
      .ADDR_W (ADDR_W)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (req_valid),
      .in_addr   (next_addr),
      .out_valid (vec_valid),
      .out_addr  (vec_addr)
   );

endmodule

// File: rtl/vecgen_chk.sv
module vecgen_chk #(
   parameter int unsigned PAGE_W     = 9,
   parameter int unsigned SLOT_W     = 5,
   parameter int unsigned WORD_SHIFT = 2,
   localparam int unsigned ADDR_W    = PAGE_W + SLOT_W + WORD_SHIFT,
   localparam int unsigned OFS_W     = SLOT_W + WORD_SHIFT
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ptr_wr,
   input logic [PAGE_W-1:0] ptr_wdata,
   input logic              req_valid,
   input logic [SLOT_W-1:0] req_num,
   input logic              req_hwrst,
   input logic [PAGE_W-1:0] page_q,
   input logic              vec_valid,
   input logic [ADDR_W-1:0] vec_addr
);

   localparam logic [ADDR_W-1:0] RESET_ADDR = {{PAGE_W{1'b1}}, {OFS_W{1'b0}}};

   // R2: a request yields a strobe on the following cycle
   p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> vec_valid);

   // R2: no request, no strobe
   p_no_req_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !vec_valid);

   // R3: slot field carries the requested vector number
   p_slot_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_hwrst) |=> vec_addr[WORD_SHIFT +: SLOT_W] == $past(req_num));

   // R6: page field comes from the pointer in the request cycle
   p_page_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_hwrst) |=> vec_addr[ADDR_W-1 -: PAGE_W] == $past(page_q));

   // R5: reset request always lands on the fixed reset address
   p_hwrst_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_hwrst) |=> vec_addr == RESET_ADDR);

   // R6: a write is visible right after the edge that samples it
   p_ptr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_wr |=> page_q == $past(ptr_wdata));

   // R7: without a write the page holds
   p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ptr_wr |=> $stable(page_q));

   // R9: presented addresses are slot aligned
   p_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> vec_addr[1:0] == 2'b00);

endmodule

bind vector_addr_gen vecgen_chk #(
   .PAGE_W     (PAGE_W),
   .SLOT_W     (SLOT_W),
   .WORD_SHIFT (WORD_SHIFT)
) u_vecgen_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ptr_wr    (ptr_wr),
   .ptr_wdata (ptr_wdata),
   .req_valid (req_valid),
   .req_num   (req_num),
   .req_hwrst (req_hwrst),
   .page_q    (page_q),
   .vec_valid (vec_valid),
   .vec_addr  (vec_addr)
);

// File: tb/test_vector_addr_gen.sv
module test_vector_addr_gen;

   localparam int PW = 9;
   localparam int SW = 5;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ptr_wr = 1'b0;
   logic [PW-1:0] ptr_wdata = '0;
   logic          req_valid = 1'b0;
   logic [SW-1:0] req_num = '0;
   logic          req_hwrst = 1'b0;
   logic          vec_valid, vec_valid_a;
   logic [AW-1:0] vec_addr, vec_addr_a;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   vector_addr_gen i_vector_addr_gen (
      .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
      .req_valid(req_valid), .req_num(req_num), .req_hwrst(req_hwrst),
      .vec_valid(vec_valid), .vec_addr(vec_addr));

   vector_addr_gen #(.USE_ADDER(1'b1)) i_vector_addr_gen_add (
      .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
      .req_valid(req_valid), .req_num(req_num), .req_hwrst(req_hwrst),
      .vec_valid(vec_valid_a), .vec_addr(vec_addr_a));

   function automatic logic [AW-1:0] exp_addr(input logic [PW-1:0] pg, input logic [SW-1:0] n);
      return (AW'(pg) << 7) | (AW'(n) << 2);
   endfunction

   task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Issue one request at a negedge; check the outputs one cycle later.
   task automatic do_req(input string req, input logic [SW-1:0] n, input logic hw,
                         input logic [AW-1:0] exp);
      @(negedge clk);
      req_valid = 1'b1; req_num = n; req_hwrst = hw;
      @(negedge clk);
      req_valid = 1'b0; req_hwrst = 1'b0;
      check({req, " valid"}, AW'(vec_valid), AW'(1));
      check({req, " addr"}, vec_addr, exp);
      check("R10 adder valid", AW'(vec_valid_a), AW'(vec_valid));
      check("R10 adder addr", vec_addr_a, vec_addr);
      @(negedge clk);
      check("R2 single pulse", AW'(vec_valid), AW'(0));
   endtask

   task automatic write_ptr(input logic [PW-1:0] v);
      @(negedge clk);
      ptr_wr = 1'b1; ptr_wdata = v;
      @(negedge clk);
      ptr_wr = 1'b0;
   endtask

   task automatic t_reset();
      // R8: requests during reset produce nothing
      req_valid = 1'b1; req_num = 5'd3;
      repeat (3) @(negedge clk);
      check("R1 valid in reset", AW'(vec_valid), AW'(0));
      check("R8 no pulse in reset", AW'(vec_valid_a), AW'(0));
      req_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after reset", AW'(vec_valid), AW'(0));
      check("R8 no late pulse", AW'(vec_valid_a), AW'(0));
   endtask

   task automatic t_default_page();
      do_req("R1 R4 slot 0", 5'd0, 1'b0, 16'hFF80);
      do_req("R4 slot 7", 5'd7, 1'b0, 16'hFF9C);
      do_req("R4 slot 31", 5'd31, 1'b0, 16'hFFFC);
   endtask

   task automatic t_relocate();
      write_ptr(9'h155);
      do_req("R7 page 155 slot 1", 5'd1, 1'b0, exp_addr(9'h155, 5'd1));
      do_req("R3 page 155 slot 21", 5'd21, 1'b0, exp_addr(9'h155, 5'd21));
      do_req("R5 hwrst after move", 5'd9, 1'b1, 16'hFF80);
      do_req("R7 page holds", 5'd10, 1'b0, exp_addr(9'h155, 5'd10));
      write_ptr(9'h000);
      do_req("R3 page 0 slot 31", 5'd31, 1'b0, 16'h007C);
      do_req("R9 page 0 slot 0", 5'd0, 1'b0, 16'h0000);
      write_ptr(9'h0AA);
      do_req("R3 page 0AA slot 10", 5'd10, 1'b0, exp_addr(9'h0AA, 5'd10));
      do_req("R5 hwrst nonzero num", 5'd31, 1'b1, 16'hFF80);
   endtask

   task automatic t_same_cycle();
      // R6: write and request on the same edge; request sees old page 0AA
      @(negedge clk);
      ptr_wr = 1'b1; ptr_wdata = 9'h033;
      req_valid = 1'b1; req_num = 5'd4; req_hwrst = 1'b0;
      @(negedge clk);
      ptr_wr = 1'b0; req_valid = 1'b0;
      check("R6 same-cycle valid", AW'(vec_valid), AW'(1));
      check("R6 same-cycle old page", vec_addr, exp_addr(9'h0AA, 5'd4));
      check("R10 adder same-cycle", vec_addr_a, vec_addr);
      do_req("R6 new page next", 5'd4, 1'b0, exp_addr(9'h033, 5'd4));
   endtask

   task automatic t_back_to_back();
      @(negedge clk);
      req_valid = 1'b1; req_num = 5'd2;
      @(negedge clk);
      req_num = 5'd3;
      check("R2 b2b first", vec_addr, exp_addr(9'h033, 5'd2));
      @(negedge clk);
      req_valid = 1'b0;
      check("R2 b2b second", vec_addr, exp_addr(9'h033, 5'd3));
      check("R2 b2b valid", AW'(vec_valid), AW'(1));
      @(negedge clk);
      check("R2 b2b end", AW'(vec_valid), AW'(0));
   endtask

   task automatic t_rereset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      do_req("R1 pointer back to 1FF", 5'd5, 1'b0, 16'hFF94);
   endtask

   initial begin
      t_reset();
      t_default_page();
      t_relocate();
      t_same_cycle();
      t_back_to_back();
      t_rereset();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule